// File: doc/BRIEF.md
# I2C Write-Then-Read Transaction Sequencer

This block runs one complete I2C transaction on its own, sitting above a byte-level I2C master engine. A request carries a 7-bit target address, a count of bytes to write and a count of bytes to read. The sequencer sends a write-addressed phase with the outgoing bytes, then, if reads are wanted, a repeated start with the read-addressed byte followed by the incoming bytes. It terminates the bus with a stop and reports one terminal status.

Outgoing bytes are pulled from a valid/ready stream and incoming bytes are pushed on another. The byte engine is driven by one-cycle command pulses (start with an address byte, continue with or without a data byte, stop, or continue plus stop). It answers by raising a pending flag together with a 3-bit situation code. Arbitration loss and start/stop framing errors reach the sequencer as separate flags, which it clears with a pulse.

Top module: `i2c_xfer_seq`

## Requirements
- R1: When the write count is nonzero, the first engine command is a start whose byte is the address in bits 7:1 with bit 0 at 0.
- R2: When the write count is zero and the read count is nonzero, the first command is a start whose byte is the address in bits 7:1 with bit 0 at 1.
- R3: A start request with both counts zero gives `done` high and status 1 (OK) in the cycle after the request, and no engine command is issued.
- R4: Each transmit-ready situation (engine code 2) takes one byte from the write stream and sends it with a continue command. After the last write byte, a nonzero read count gives a repeated start with the read address, and a zero read count gives a stop. Status becomes 1 once the engine reports idle (code 0) with nothing left to do.
- R5: Each receive-ready situation (engine code 1) hands one byte to the read stream, and it waits while `rx_ready` is low. It answers with a continue, and the final byte is answered with continue plus stop.
- R6: An address NACK (engine code 3) sets status 2 and issues a stop.
- R7: A data NACK (engine code 4) sets status 3 and issues a stop.
- R8: Arbitration loss sets status 4 and pulses the flag clear. A continue command is added when the engine is pending. Arbitration takes priority over a framing error.
- R9: A framing error sets status 5 and pulses the flag clear. When the engine is not pending, no command is sent.
- R10: Any other pending engine code (5 to 7) sets status 6 and issues a continue.
- R11: An accepted start sets status 0 (busy). In the next cycle it pulses `eng_reset` and `eng_flag_clr` together, and engine inputs are ignored in that cycle.
- R12: `done` is a one-cycle pulse in the cycle the status first holds a terminal value. A start request while status is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transaction request |
| target_addr | input | ADDR_W | 7-bit target address |
| tx_count | input | CNT_W | Number of bytes to write |
| rx_count | input | CNT_W | Number of bytes to read |
| tx_data | input | DATA_W | Write stream byte |
| tx_valid | input | 1 | Write stream valid |
| tx_ready | output | 1 | Write stream ready |
| rx_data | output | DATA_W | Read stream byte |
| rx_valid | output | 1 | Read stream valid |
| rx_ready | input | 1 | Read stream ready |
| status | output | 3 | 0 busy, 1 OK, 2 address NACK, 3 data NACK, 4 arbitration lost, 5 bus error, 6 error |
| done | output | 1 | Completion pulse |
| eng_reset | output | 1 | Engine state reset pulse |
| eng_flag_clr | output | 1 | Clear arbitration and framing flags |
| eng_cmd_valid | output | 1 | Engine command pulse |
| eng_cmd_start | output | 1 | Command: (repeated) start with address byte |
| eng_cmd_cont | output | 1 | Command: continue |
| eng_cmd_stop | output | 1 | Command: stop |
| eng_cmd_data | output | DATA_W | Byte sent with the command |
| eng_pending | input | 1 | Engine awaits a command |
| eng_code | input | 3 | Engine situation: 0 idle, 1 receive ready, 2 transmit ready, 3 address NACK, 4 data NACK |
| eng_rx_byte | input | DATA_W | Byte received by the engine |
| eng_arb_lost | input | 1 | Arbitration lost flag |
| eng_bus_err | input | 1 | Start/stop framing error flag |

## Verification
The assertions assume the engine follows its handshake. It drops `eng_pending` in the cycle after a command pulse and keeps its code and received byte steady while pending. A flag clear takes effect at the next edge, and after `eng_reset` the engine is pending and idle. The bench engine model keeps to this contract. It answers each command after a random delay of one to three cycles and injects NACKs, arbitration loss, framing errors and illegal codes only at the points of the write phase where the model expects them. The write and read streams stall at random.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

   typedef enum logic [2:0] {
      ST_BUSY      = 3'd0,
      ST_OK        = 3'd1,
      ST_NACK_ADDR = 3'd2,
      ST_NACK_DATA = 3'd3,
      ST_ARB       = 3'd4,
      ST_BUS_ERR   = 3'd5,
      ST_ERROR     = 3'd6
   } seq_status_e;

   localparam logic [2:0] ENG_IDLE      = 3'd0;
   localparam logic [2:0] ENG_RX_RDY    = 3'd1;
   localparam logic [2:0] ENG_TX_RDY    = 3'd2;
   localparam logic [2:0] ENG_NACK_ADDR = 3'd3;
   localparam logic [2:0] ENG_NACK_DATA = 3'd4;

endpackage

// File: rtl/i2c_seq_counter.sv
module i2c_seq_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero,
   output logic         last
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && (cnt_q != '0))
         cnt_q <= cnt_q - ONE;
   end

   assign zero = (cnt_q == '0);
   assign last = (cnt_q == ONE);
endmodule

// File: rtl/i2c_seq_cmd_reg.sv
module i2c_seq_cmd_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              c_start,
   input  logic              c_cont,
   input  logic              c_stop,
   input  logic [DATA_W-1:0] c_data,
   input  logic              rst_req,
   input  logic              clr_req,
   output logic              cmd_valid,
   output logic              cmd_start,
   output logic              cmd_cont,
   output logic              cmd_stop,
   output logic [DATA_W-1:0] cmd_data,
   output logic              eng_rst,
   output logic              flag_clr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_start <= 1'b0;
         cmd_cont  <= 1'b0;
         cmd_stop  <= 1'b0;
         cmd_data  <= '0;
         eng_rst   <= 1'b0;
         flag_clr  <= 1'b0;
      end else begin
         cmd_valid <= issue;
         cmd_start <= issue & c_start;
         cmd_cont  <= issue & c_cont;
         cmd_stop  <= issue & c_stop;
         if (issue)
            cmd_data <= c_data;
         eng_rst   <= rst_req;
         flag_clr  <= clr_req;
      end
   end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
   import i2c_seq_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] target_addr,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [2:0]        status,
   output logic              done,
   output logic              eng_reset,
   output logic              eng_flag_clr,
   output logic              eng_cmd_valid,
   output logic              eng_cmd_start,
   output logic              eng_cmd_cont,
   output logic              eng_cmd_stop,
   output logic [DATA_W-1:0] eng_cmd_data,
   input  logic              eng_pending,
   input  logic [2:0]        eng_code,
   input  logic [DATA_W-1:0] eng_rx_byte,
   input  logic              eng_arb_lost,
   input  logic              eng_bus_err
);
   localparam int ABYTE_W = ADDR_W + 1;

   generate
      if (ABYTE_W != DATA_W) begin : g_bad_width
         $error("address byte must fill exactly one data byte");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("count width must be at least one bit");
      end
   endgenerate

   seq_status_e       status_q;
   logic              done_q;
   logic [ADDR_W-1:0] addr_q;
   logic              busy, start_acc, guard, evt_flag, evt_pend;
   logic              tx_zero, tx_last, rx_zero, rx_last;
   logic              tx_dec, rx_dec;
   logic              go, c_start, c_cont, c_stop, clr_req, fin;
   logic [DATA_W-1:0] c_data;
   seq_status_e       fin_code;

   assign busy      = (status_q == ST_BUSY);
   assign start_acc = start && !busy;
   // Engine inputs are trusted only when no command, reset or clear is in flight.
   assign guard     = busy && !eng_cmd_valid && !eng_reset && !eng_flag_clr;
   assign evt_flag  = guard && (eng_arb_lost || eng_bus_err);
   assign evt_pend  = guard && !evt_flag && eng_pending;

   assign tx_ready  = evt_pend && (eng_code == ENG_TX_RDY) && !tx_zero;
   assign rx_valid  = evt_pend && (eng_code == ENG_RX_RDY) && !rx_zero;
   assign rx_data   = eng_rx_byte;

   i2c_seq_counter #(.W(CNT_W)) i_tx_cnt (
      .clk(clk), .rst_n(rst_n), .load(start_acc), .load_val(tx_count),
      .dec(tx_dec), .zero(tx_zero), .last(tx_last)
   );

   i2c_seq_counter #(.W(CNT_W)) i_rx_cnt (
      .clk(clk), .rst_n(rst_n), .load(start_acc), .load_val(rx_count),
      .dec(rx_dec), .zero(rx_zero), .last(rx_last)
   );

   always_comb begin
      go       = 1'b0;
      c_start  = 1'b0;
      c_cont   = 1'b0;
      c_stop   = 1'b0;
      c_data   = '0;
      clr_req  = 1'b0;
      fin      = 1'b0;
      fin_code = ST_OK;
      tx_dec   = 1'b0;
      rx_dec   = 1'b0;
      if (evt_flag) begin
         clr_req  = 1'b1;
         fin      = 1'b1;
         fin_code = eng_arb_lost ? ST_ARB : ST_BUS_ERR;
         if (eng_pending) begin
            go     = 1'b1;
            c_cont = 1'b1;
         end
      end else if (evt_pend) begin
         case (eng_code)
            ENG_IDLE: begin
               if (!tx_zero) begin
                  go      = 1'b1;
                  c_start = 1'b1;
                  c_data  = {addr_q, 1'b0};
               end else if (!rx_zero) begin
                  go      = 1'b1;
                  c_start = 1'b1;
                  c_data  = {addr_q, 1'b1};
               end else begin
                  fin = 1'b1;
               end
            end
            ENG_RX_RDY: begin
               if (rx_zero) begin
                  go     = 1'b1;
                  c_cont = 1'b1;
                  c_stop = 1'b1;
               end else if (rx_ready) begin
                  rx_dec = 1'b1;
                  go     = 1'b1;
                  c_cont = 1'b1;
                  c_stop = rx_last;
               end
            end
            ENG_TX_RDY: begin
               if (!tx_zero) begin
                  if (tx_valid) begin
                     tx_dec = 1'b1;
                     go     = 1'b1;
                     c_cont = 1'b1;
                     c_data = tx_data;
                  end
               end else if (rx_zero) begin
                  go     = 1'b1;
                  c_stop = 1'b1;
               end else begin
                  go      = 1'b1;
                  c_start = 1'b1;
                  c_data  = {addr_q, 1'b1};
               end
            end
            ENG_NACK_ADDR: begin
               fin      = 1'b1;
               fin_code = ST_NACK_ADDR;
               go       = 1'b1;
               c_stop   = 1'b1;
            end
            ENG_NACK_DATA: begin
               fin      = 1'b1;
               fin_code = ST_NACK_DATA;
               go       = 1'b1;
               c_stop   = 1'b1;
            end
            default: begin
               fin      = 1'b1;
               fin_code = ST_ERROR;
               go       = 1'b1;
               c_cont   = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= ST_OK;
         done_q   <= 1'b0;
         addr_q   <= '0;
      end else if (start_acc) begin
         addr_q <= target_addr;
         if ((tx_count == '0) && (rx_count == '0)) begin
            status_q <= ST_OK;
            done_q   <= 1'b1;
         end else begin
            status_q <= ST_BUSY;
            done_q   <= 1'b0;
         end
      end else if (fin) begin
         status_q <= fin_code;
         done_q   <= 1'b1;
      end else begin
         done_q <= 1'b0;
      end
   end

   i2c_seq_cmd_reg #(.DATA_W(DATA_W)) i_cmd (
      .clk(clk), .rst_n(rst_n), .issue(go), .c_start(c_start), .c_cont(c_cont),
      .c_stop(c_stop), .c_data(c_data), .rst_req(start_acc),
      .clr_req(start_acc || clr_req), .cmd_valid(eng_cmd_valid),
      .cmd_start(eng_cmd_start), .cmd_cont(eng_cmd_cont), .cmd_stop(eng_cmd_stop),
      .cmd_data(eng_cmd_data), .eng_rst(eng_reset), .flag_clr(eng_flag_clr)
   );

   assign status = status_q;
   assign done   = done_q;
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [CNT_W-1:0] tx_count,
   input logic [CNT_W-1:0] rx_count,
   input logic             rx_valid,
   input logic             rx_ready,
   input logic [2:0]       status,
   input logic             done,
   input logic             eng_reset,
   input logic             eng_flag_clr,
   input logic             eng_cmd_valid,
   input logic             eng_cmd_start,
   input logic             eng_cmd_cont,
   input logic             eng_cmd_stop,
   input logic             eng_pending,
   input logic [2:0]       eng_code,
   input logic             eng_arb_lost,
   input logic             eng_bus_err
);
   logic quiet;
   assign quiet = (status == 3'd0) && !eng_cmd_valid && !eng_reset && !eng_flag_clr
                  && !eng_arb_lost && !eng_bus_err && eng_pending;

   // R11
   accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && (status != 3'd0) |=> eng_reset && eng_flag_clr);

   // R12
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && (status == 3'd0) |=> !eng_reset);

   // R3
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && (status != 3'd0) && (tx_count == '0) && (rx_count == '0)
      |=> done && (status == 3'd1) && !eng_cmd_valid);

   // R12
   done_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status != 3'd0));

   // R6
   nack_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      quiet && (eng_code == 3'd3) |=> (status == 3'd2) && eng_cmd_valid && eng_cmd_stop && !eng_cmd_cont);

   // R7
   nack_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      quiet && (eng_code == 3'd4) |=> (status == 3'd3) && eng_cmd_valid && eng_cmd_stop && !eng_cmd_cont);

   // R8
   arb_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 3'd0) && eng_arb_lost && !eng_cmd_valid && !eng_reset && !eng_flag_clr
      |=> (status == 3'd4) && eng_flag_clr);

   // R5
   rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_ready |=> !eng_cmd_valid);

   // R4
   cmd_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid |-> !(eng_cmd_start && (eng_cmd_cont || eng_cmd_stop))
                        && (eng_cmd_start || eng_cmd_cont || eng_cmd_stop));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_seq_chk (.*);

// File: tb/test_i2c_xfer_seq.sv
`timescale 1ns/1ps
module test_i2c_xfer_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [6:0] target_addr = '0;
   logic [7:0] tx_count = '0, rx_count = '0;
   logic [7:0] tx_data = '0;
   logic       tx_valid = 1'b0, tx_ready;
   logic [7:0] rx_data;
   logic       rx_valid, rx_ready = 1'b0;
   logic [2:0] status;
   logic       done, eng_reset, eng_flag_clr;
   logic       eng_cmd_valid, eng_cmd_start, eng_cmd_cont, eng_cmd_stop;
   logic [7:0] eng_cmd_data;
   logic       eng_pending = 1'b0;
   logic [2:0] eng_code = '0;
   logic [7:0] eng_rx_byte = '0;
   logic       eng_arb_lost = 1'b0, eng_bus_err = 1'b0;

   always #2 clk = ~clk;

   i2c_xfer_seq i_i2c_xfer_seq (.*);

   int checks = 0, errors = 0;
   int s_tx = 0, s_rx = 0, s_nwr = 0, s_nrd = 0, s_ill = 0;
   int s_ndat = -1, s_arb = -1, s_berr = -1;
   logic [7:0] txbuf [16];
   logic [7:0] wr_log [16];
   logic [7:0] addr_log [4];
   logic [7:0] rx_log [16];
   int n_starts = 0, n_stops = 0, wr_cnt = 0, rd_idx = 0, rx_cnt = 0, done_cnt = 0, saw_cs = 0;
   int tx_idx = 0;
   int sch_cnt = 0;
   logic [2:0] sch_code = '0;
   logic sch_pend = 1'b0, sch_arb = 1'b0, sch_berr = 1'b0;
   logic [7:0] sch_rd = '0;

   function automatic logic [7:0] rd_pat(int i);
      return 8'((i * 29 + 90) & 255);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Byte engine model
   always @(posedge clk) begin
      if (eng_reset) begin
         eng_pending <= 1'b1; eng_code <= 3'd0; eng_arb_lost <= 1'b0; eng_bus_err <= 1'b0;
         sch_cnt = 0; n_starts = 0; n_stops = 0; wr_cnt = 0; rd_idx = 0; saw_cs = 0;
      end else begin
         if (eng_flag_clr) begin eng_arb_lost <= 1'b0; eng_bus_err <= 1'b0; end
         if (eng_cmd_valid) begin
            eng_pending <= 1'b0;
            sch_pend = 1'b1; sch_arb = 1'b0; sch_berr = 1'b0; sch_code = 3'd0;
            sch_cnt = 1 + int'($urandom % 3);
            if (eng_cmd_start) begin
               if (n_starts < 4) addr_log[n_starts] = eng_cmd_data;
               n_starts++;
               if (!eng_cmd_data[0]) sch_code = (s_nwr != 0) ? 3'd3 : (s_ill != 0) ? 3'd7 : 3'd2;
               else begin sch_code = (s_nrd != 0) ? 3'd3 : 3'd1; sch_rd = rd_pat(rd_idx); end
            end else if (eng_cmd_cont && eng_code == 3'd2) begin
               wr_log[wr_cnt] = eng_cmd_data;
               if (wr_cnt == s_arb) sch_arb = 1'b1;
               else if (wr_cnt == s_berr) begin sch_berr = 1'b1; sch_pend = 1'b0; end
               else if (wr_cnt == s_ndat) sch_code = 3'd4;
               else sch_code = 3'd2;
               wr_cnt++;
            end else if (eng_cmd_cont && eng_code == 3'd1) begin
               rd_idx++;
               if (eng_cmd_stop) begin n_stops++; saw_cs = 1; end
               else begin sch_code = 3'd1; sch_rd = rd_pat(rd_idx); end
            end else if (eng_cmd_stop) begin
               n_stops++;
            end else begin
               sch_cnt = 0;
            end
         end else if (sch_cnt > 0) begin
            if (sch_cnt == 1) begin
               eng_pending <= sch_pend; eng_code <= sch_code; eng_rx_byte <= sch_rd;
               if (sch_arb) eng_arb_lost <= 1'b1;
               if (sch_berr) eng_bus_err <= 1'b1;
            end
            sch_cnt--;
         end
      end
   end

   // Streams and done monitor
   always @(posedge clk) begin
      int ni;
      if (eng_reset) begin ni = 0; rx_cnt = 0; end
      else begin
         ni = tx_idx + ((tx_valid && tx_ready) ? 1 : 0);
         if (rx_valid && rx_ready) begin rx_log[rx_cnt] = rx_data; rx_cnt++; end
      end
      tx_idx = ni;
      tx_data <= txbuf[ni % 16];
      tx_valid <= (ni < s_tx) && ($urandom % 4 != 0);
      rx_ready <= ($urandom % 3 != 0);
      if (done) done_cnt++;
   end

   // kind: 0 none, 1 write-address NACK, 2 read-address NACK, 3 data NACK, 4 arbitration, 5 framing, 6 illegal
   task automatic run(int tx, int rx, int kind, int idx, bit poke);
      int exp_st, exp_wr, exp_starts, exp_stops, nz, ok_rd;
      logic [6:0] a;
      s_tx = tx; s_rx = rx; s_nwr = 0; s_nrd = 0; s_ill = 0; s_ndat = -1; s_arb = -1; s_berr = -1;
      case (kind)
         1: s_nwr = 1; 2: s_nrd = 1; 3: s_ndat = idx; 4: s_arb = idx; 5: s_berr = idx; 6: s_ill = 1;
         default: ;
      endcase
      for (int i = 0; i < 16; i++) txbuf[i] = 8'($urandom);
      a = 7'($urandom);
      nz = (tx != 0 || rx != 0);
      exp_st = 1; exp_wr = tx; exp_stops = nz;
      if (tx > 0) begin
         if (kind == 1) begin exp_st = 2; exp_wr = 0; end
         else if (kind == 6) begin exp_st = 6; exp_wr = 0; exp_stops = 0; end
         else if (kind == 3) begin exp_st = 3; exp_wr = idx + 1; end
         else if (kind == 4) begin exp_st = 4; exp_wr = idx + 1; exp_stops = 0; end
         else if (kind == 5) begin exp_st = 5; exp_wr = idx + 1; exp_stops = 0; end
      end
      ok_rd = (kind == 0 || kind == 2);
      exp_starts = (tx > 0 ? 1 : 0) + ((rx > 0 && ok_rd) ? 1 : 0);
      if (rx > 0 && kind == 2) exp_st = 2;
      done_cnt = 0;
      @(negedge clk);
      start = 1'b1; target_addr = a; tx_count = 8'(tx); rx_count = 8'(rx);
      @(negedge clk);
      start = 1'b0;
      if (nz) chk(eng_reset && eng_flag_clr && status == 3'd0, "R11", int'(status), 0);
      else chk(done && status == 3'd1, "R3", int'(status), 1);
      if (poke) begin
         @(negedge clk); @(negedge clk);
         start = 1'b1; target_addr = ~a; tx_count = 8'd0; rx_count = 8'd0;
         @(negedge clk); start = 1'b0;
         @(negedge clk);
         chk(status == 3'd0 && !done, "R12 busy start ignored", int'(status), 0);
      end
      for (int c = 0; c < 3000 && !done && nz; c++) @(negedge clk);
      repeat (12) @(negedge clk);
      chk(int'(status) == exp_st, "R4-status", int'(status), exp_st);
      chk(done_cnt == 1, "R12 done pulses", done_cnt, 1);
      chk(n_starts == exp_starts, "R4 starts", n_starts, exp_starts);
      chk(n_stops == exp_stops, "R6/R7 stops", n_stops, exp_stops);
      chk(wr_cnt == exp_wr, "R4 bytes written", wr_cnt, exp_wr);
      for (int i = 0; i < exp_wr && i < wr_cnt; i++)
         chk(wr_log[i] == txbuf[i], "R4 write data", int'(wr_log[i]), int'(txbuf[i]));
      if (tx > 0) chk(addr_log[0] == {a, 1'b0}, "R1 write address", int'(addr_log[0]), int'({a, 1'b0}));
      else if (rx > 0) chk(addr_log[0] == {a, 1'b1}, "R2 read address", int'(addr_log[0]), int'({a, 1'b1}));
      if (tx > 0 && rx > 0 && ok_rd)
         chk(addr_log[1] == {a, 1'b1}, "R4 repeated start", int'(addr_log[1]), int'({a, 1'b1}));
      if (exp_st == 1 && rx > 0) begin
         chk(rx_cnt == rx, "R5 bytes read", rx_cnt, rx);
         chk(saw_cs == 1, "R5 continue with stop", saw_cs, 1);
         for (int i = 0; i < rx && i < rx_cnt; i++)
            chk(rx_log[i] == rd_pat(i), "R5 read data", int'(rx_log[i]), int'(rd_pat(i)));
      end
      if (kind == 4) chk(!eng_arb_lost, "R8 flag cleared", int'(eng_arb_lost), 0);
      if (kind == 5) chk(!eng_bus_err, "R9 flag cleared", int'(eng_bus_err), 0);
      if (kind == 6) chk(status == 3'd6, "R10 illegal code", int'(status), 6);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(status == 3'd1 && !done && !eng_cmd_valid && !tx_ready && !rx_valid, "R12 reset state", int'(status), 1);
      run(0, 0, 0, 0, 1'b0);
      run(3, 0, 0, 0, 1'b0);
      run(0, 4, 0, 0, 1'b0);
      run(2, 3, 0, 0, 1'b0);
      run(1, 1, 0, 0, 1'b0);
      run(2, 2, 1, 0, 1'b0);
      run(0, 2, 2, 0, 1'b0);
      run(3, 2, 2, 0, 1'b0);
      run(4, 1, 3, 2, 1'b0);
      run(3, 0, 4, 1, 1'b0);
      run(3, 2, 5, 0, 1'b0);
      run(2, 1, 6, 0, 1'b0);
      run(5, 2, 0, 0, 1'b1);
      for (int n = 0; n < 40; n++) begin
         int tx, rx, kind, idx;
         tx = int'($urandom % 6); rx = int'($urandom % 6);
         kind = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 6);
         idx = (tx > 0) ? int'($urandom % tx) : 0;
         if ((kind == 2 && rx == 0) || (kind != 2 && kind != 0 && tx == 0)) kind = 0;
         run(tx, rx, kind, idx, 1'b0);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule